// File: doc/BRIEF.md
# Asynchronous 2K x 8 SRAM Cycle Controller

This block sits between a synchronous host and a 2048 x 8 asynchronous static memory. The host hands it a single request: an address, a direction flag and, for a store, a data byte. The controller then runs the memory bus through a fixed sequence of phases. Each phase lasts a whole number of system clock cycles. It asserts the chip select, output enable and write strobe (all active low) at the right moments, and it drives the data bus only while a store needs it. When a load completes, it returns the byte it sampled together with a one-cycle completion pulse.

Phase lengths come from a built-in timing table indexed by a speed-grade parameter. Each phase length is the table time divided by the clock period, rounded up. A slot holds one request. A request that arrives while a cycle or its recovery gap is still running waits in that slot and starts as soon as the controller returns to idle.

Top module: `async_sram_ctl`

## Requirements
- R1: After reset, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, done is 0 and req_ready is 1.
- R2: A load (req_we=0) holds mem_ce_n and mem_oe_n low with mem_we_n high for exactly RD_CYC = ceil(max(t_acc, t_ce_acc, t_oe_acc) / clock period) cycles. With grade 1 and a 10 ns clock this is 12 cycles.
- R3: On the clock edge that ends the load's access phase, the controller captures mem_dq_in into rdata and pulses done. rdata keeps that value until the next load completes.
- R4: A store (req_we=1) first spends one setup cycle with mem_ce_n low and mem_we_n high. It then holds mem_we_n low for WP_CYC = max(ceil(max(t_wp, t_ds)/period), ceil(t_cycle/period) - 2) cycles, which is 10 cycles for grade 1 at 10 ns. After that comes one hold cycle with mem_ce_n still low. mem_oe_n stays 1 for the whole store.
- R5: mem_dq_oe is 1 exactly while mem_we_n is low plus the single cycle after it rises, so 11 cycles for the default bench setup. At all other times it is 0, and it is never 1 while mem_oe_n is 0.
- R6: mem_addr does not change while mem_ce_n is low.
- R7: After mem_ce_n rises it stays high for at least REC_CYC = max(1, ceil(t_rec_ce/period)) cycles. A waiting request lowers mem_ce_n exactly REC_CYC+1 cycles after that rise.
- R8: A request offered when req_ready is 1 is held in one slot, and req_ready is 0 while the slot is full. The held address, data and direction are carried out unchanged once the controller is idle.
- R9: done is a single-cycle pulse. For a store, it appears on the same edge on which mem_ce_n rises, one cycle after mem_we_n rises.
- R10: A store followed by a load to the same address returns the stored byte. This holds at address 0, at address 2047, and for the data patterns 00, FF, A5 and 5A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, taken when req_ready is 1 |
| req_ready | output | 1 | Request slot is empty |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 8 | Store data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Load result, valid with done |
| mem_addr | output | 11 | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
The bench memory model returns a poison byte until chip select and output enable have been low for the full access time. A controller that samples even one cycle early therefore returns the poison byte instead of the stored data. The strobe, drive-enable and chip-select cycles are counted per operation, so a write pulse that is one cycle short, or a data bus released together with the write strobe instead of one cycle later, changes a count. A second request is issued while a store is still running. If the recovery gap is skipped, the chip-select high gap changes. If the held slot is corrupted or lost, the read-after-write value is wrong.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ACC,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_HOLD,
      ST_RECOVER
   } ctl_state_e;

   typedef enum int {
      TM_CYCLE,
      TM_ACC,
      TM_CE_ACC,
      TM_OE_ACC,
      TM_WP,
      TM_DS,
      TM_REC_CE
   } timing_e;

   localparam int NUM_GRADES = 4;

   // speed-grade timing table in nanoseconds
   function automatic int grade_time_ns(input int grade, input timing_e which);
      int t;
      case (which)
         TM_CYCLE, TM_ACC, TM_CE_ACC:
            case (grade)
               0: t = 100;
               1: t = 120;
               2: t = 150;
               default: t = 200;
            endcase
         TM_OE_ACC:
            case (grade)
               0: t = 50;
               1: t = 60;
               2: t = 70;
               default: t = 100;
            endcase
         TM_WP:
            case (grade)
               0: t = 75;
               1: t = 90;
               2: t = 100;
               default: t = 150;
            endcase
         TM_DS:
            case (grade)
               0: t = 40;
               1: t = 50;
               2: t = 60;
               default: t = 80;
            endcase
         default: t = 10;
      endcase
      return t;
   endfunction

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (CNT_W >= 1) else $error("sram_phase_timer: CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_req_hold.sv
module sram_req_hold #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              push_we,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic              full,
   output logic              held_we,
   output logic [ADDR_W-1:0] held_addr,
   output logic [DATA_W-1:0] held_data
);

   logic valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q   <= 1'b0;
         held_we   <= 1'b0;
         held_addr <= '0;
         held_data <= '0;
      end else if (push && !valid_q) begin
         valid_q   <= 1'b1;
         held_we   <= push_we;
         held_addr <= push_addr;
         held_data <= push_data;
      end else if (pop) begin
         valid_q   <= 1'b0;
      end
   end

   assign full = valid_q;

   // slot content must not change while it waits
   assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && $past(valid_q) && !$past(pop)) |->
         ($stable(held_addr) && $stable(held_data) && $stable(held_we)));

endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int CLK_PERIOD_NS = 10,
   parameter int SPEED_GRADE   = 0,
   parameter int ADDR_W        = 11,
   parameter int DATA_W        = 8,
   parameter bit PARK_DQ_LOW   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   // ---------------- derived phase lengths ----------------
   localparam int T_CYC   = grade_time_ns(SPEED_GRADE, TM_CYCLE);
   localparam int T_ACC   = grade_time_ns(SPEED_GRADE, TM_ACC);
   localparam int T_CEA   = grade_time_ns(SPEED_GRADE, TM_CE_ACC);
   localparam int T_OEA   = grade_time_ns(SPEED_GRADE, TM_OE_ACC);
   localparam int T_WP    = grade_time_ns(SPEED_GRADE, TM_WP);
   localparam int T_DS    = grade_time_ns(SPEED_GRADE, TM_DS);
   localparam int T_REC   = grade_time_ns(SPEED_GRADE, TM_REC_CE);

   localparam int RD_CYC  = max2(1, ceil_div(max2(T_ACC, max2(T_CEA, T_OEA)), CLK_PERIOD_NS));
   localparam int WP_CYC  = max2(1, max2(ceil_div(max2(T_WP, T_DS), CLK_PERIOD_NS),
                                         ceil_div(T_CYC, CLK_PERIOD_NS) - 2));
   localparam int REC_CYC = max2(1, ceil_div(T_REC, CLK_PERIOD_NS));
   localparam int MAX_CYC = max2(RD_CYC, max2(WP_CYC, REC_CYC));
   localparam int CNT_W   = max2(1, $clog2(MAX_CYC + 1));

   localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WP_LOAD  = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(REC_CYC - 1);

   initial begin
      assert (CLK_PERIOD_NS > 0) else $error("async_sram_ctl: clock period must be positive");
      assert (SPEED_GRADE >= 0 && SPEED_GRADE < NUM_GRADES)
         else $error("async_sram_ctl: unknown speed grade");
      assert (ADDR_W >= 1 && DATA_W >= 1) else $error("async_sram_ctl: bad bus widths");
   end

   // ---------------- request slot ----------------
   logic              slot_full;
   logic              slot_we;
   logic [ADDR_W-1:0] slot_addr;
   logic [DATA_W-1:0] slot_data;
   logic              slot_pop;

   sram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (req),
      .push_we   (req_we),
      .push_addr (req_addr),
      .push_data (req_wdata),
      .pop       (slot_pop),
      .full      (slot_full),
      .held_we   (slot_we),
      .held_addr (slot_addr),
      .held_data (slot_data)
   );

   assign req_ready = !slot_full;

   // ---------------- phase timer ----------------
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   // ---------------- sequencer ----------------
   ctl_state_e state_q, state_d;
   logic       start;
   logic       finish_rd;
   logic       finish_wr;

   always_comb begin
      state_d   = state_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      start     = 1'b0;
      finish_rd = 1'b0;
      finish_wr = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (slot_full) begin
               start = 1'b1;
               if (slot_we) begin
                  state_d = ST_WR_SETUP;
               end else begin
                  state_d  = ST_RD_ACC;
                  tmr_load = 1'b1;
                  tmr_val  = RD_LOAD;
               end
            end
         end
         ST_RD_ACC: begin
            if (tmr_expired) begin
               state_d   = ST_RECOVER;
               finish_rd = 1'b1;
               tmr_load  = 1'b1;
               tmr_val   = REC_LOAD;
            end
         end
         ST_WR_SETUP: begin
            state_d  = ST_WR_PULSE;
            tmr_load = 1'b1;
            tmr_val  = WP_LOAD;
         end
         ST_WR_PULSE: begin
            if (tmr_expired) begin
               state_d = ST_WR_HOLD;
            end
         end
         ST_WR_HOLD: begin
            state_d   = ST_RECOVER;
            finish_wr = 1'b1;
            tmr_load  = 1'b1;
            tmr_val   = REC_LOAD;
         end
         ST_RECOVER: begin
            if (tmr_expired) begin
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign slot_pop = start;

   // ---------------- registered bus controls ----------------
   logic              ce_n_d, we_n_d, oe_n_d, dq_oe_d;
   logic              dq_oe_q;
   logic [DATA_W-1:0] wdata_q;

   always_comb begin
      ce_n_d  = !(state_d == ST_RD_ACC   || state_d == ST_WR_SETUP ||
                  state_d == ST_WR_PULSE || state_d == ST_WR_HOLD);
      oe_n_d  = (state_d != ST_RD_ACC);
      we_n_d  = (state_d != ST_WR_PULSE);
      dq_oe_d = (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         mem_ce_n <= 1'b1;
         mem_we_n <= 1'b1;
         mem_oe_n <= 1'b1;
         dq_oe_q  <= 1'b0;
         mem_addr <= '0;
         wdata_q  <= '0;
         done     <= 1'b0;
         rdata    <= '0;
      end else begin
         state_q  <= state_d;
         mem_ce_n <= ce_n_d;
         mem_we_n <= we_n_d;
         mem_oe_n <= oe_n_d;
         dq_oe_q  <= dq_oe_d;
         done     <= finish_rd || finish_wr;
         if (start) begin
            mem_addr <= slot_addr;
            wdata_q  <= slot_data;
         end
         if (finish_rd) begin
            rdata <= mem_dq_in;
         end
      end
   end

   assign mem_dq_oe = dq_oe_q;

   generate
      if (PARK_DQ_LOW) begin : g_park_low
         assign mem_dq_out = dq_oe_q ? wdata_q : '0;
      end else begin : g_park_hold
         assign mem_dq_out = wdata_q;
      end
   endgenerate

   // ---------------- assertions ----------------
   logic [CNT_W:0] we_low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_low_cnt <= '0;
      end else if (!mem_we_n) begin
         if (we_low_cnt != '1) we_low_cnt <= we_low_cnt + 1'b1;
      end else begin
         we_low_cnt <= '0;
      end
   end

   assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_ce_n && mem_we_n));

   assert_we_after_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(mem_we_n)));

   assert_we_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_low_cnt == (CNT_W+1)'(WP_CYC)));

   assert_data_driven_in_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_dq_oe);

   assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   assert_recovery_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_ce_n) |=> mem_ce_n);

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_with_ce_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($rose(mem_ce_n)));

endmodule

// File: tb/tb_async_sram_ctl.sv
module tb_async_sram_ctl;

   localparam int CLK_PERIOD = 10;
   localparam int GRADE      = 1;
   // expected phase lengths for grade 1 at 10 ns, from the requirements
   localparam int EXP_RD   = 12;   // R2: ceil(120/10)
   localparam int EXP_WP   = 10;   // R4: max(ceil(90/10), 12-2)
   localparam int EXP_REC  = 1;    // R7: max(1, ceil(10/10))
   localparam int T_ACC_NS = 120;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic       req_ready;
   logic       req_we = 1'b0;
   logic [10:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic       done;
   logic [7:0]  rdata;
   logic [10:0] mem_addr;
   logic       mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in = 8'hEE;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   async_sram_ctl #(.CLK_PERIOD_NS(CLK_PERIOD), .SPEED_GRADE(GRADE)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_ready(req_ready), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // ---------- memory model ----------
   logic [7:0] mem [0:2047];
   int         acc_low = 0;

   always @(posedge mem_we_n) begin
      if (!mem_ce_n) mem[mem_addr] = mem_dq_oe ? mem_dq_out : 8'hDD;
   end

   // data becomes valid only after the full access time with CE and OE low
   always @(negedge clk) begin
      if (!mem_ce_n && !mem_oe_n && mem_we_n) acc_low = acc_low + 1;
      else acc_low = 0;
      mem_dq_in = (acc_low * CLK_PERIOD >= T_ACC_NS) ? mem[mem_addr] : 8'hEE;
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic issue(input bit we, input logic [10:0] a, input logic [7:0] d);
      @(negedge clk);
      for (int i = 0; i < 100 && !req_ready; i++) @(negedge clk);
      req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic t_reset();
      chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
      chk(!mem_dq_oe && !done, "R1 dq_oe/done", {mem_dq_oe, done}, 0);
      chk(req_ready, "R1 req_ready", req_ready, 1);
   endtask

   task automatic t_write(input logic [10:0] a, input logic [7:0] d);
      int ce_lo = 0, we_lo = 0, dq = 0, oe_lo = 0, addr_bad = 0;
      issue(1'b1, a, d);
      for (int i = 0; i < 200 && !done; i++) begin
         if (!mem_ce_n) begin ce_lo++; if (mem_addr != a) addr_bad++; end
         if (!mem_we_n) we_lo++;
         if (mem_dq_oe) begin dq++; if (mem_dq_out != d) addr_bad++; end
         if (!mem_oe_n) oe_lo++;
         @(negedge clk);
      end
      chk(we_lo == EXP_WP, "R4 we low cycles", we_lo, EXP_WP);
      chk(ce_lo == EXP_WP + 2, "R4 ce low cycles", ce_lo, EXP_WP + 2);
      chk(oe_lo == 0, "R4 oe during write", oe_lo, 0);
      chk(dq == EXP_WP + 1, "R5 dq drive cycles", dq, EXP_WP + 1);
      chk(addr_bad == 0, "R6 addr/data stable", addr_bad, 0);
      chk(done && mem_ce_n && !mem_dq_oe, "R9 done with ce rise", {done, mem_ce_n, mem_dq_oe}, 6);
      @(negedge clk);
      chk(!done, "R9 done single cycle", done, 0);
   endtask

   task automatic t_read(input logic [10:0] a, input logic [7:0] exp);
      int ce_lo = 0, oe_lo = 0, bad = 0;
      issue(1'b0, a, 8'h00);
      for (int i = 0; i < 200 && !done; i++) begin
         if (!mem_ce_n) ce_lo++;
         if (!mem_oe_n) oe_lo++;
         if (!mem_we_n || mem_dq_oe) bad++;
         @(negedge clk);
      end
      chk(ce_lo == EXP_RD && oe_lo == EXP_RD, "R2 access cycles", ce_lo, EXP_RD);
      chk(bad == 0, "R2 we/dq idle in read", bad, 0);
      chk(rdata == exp, "R3/R10 rdata", rdata, exp);
      @(negedge clk);
      chk(!done && rdata == exp, "R3 rdata held", rdata, exp);
   endtask

   task automatic t_queued();
      int gap = 0;
      issue(1'b1, 11'h155, 8'h3C);
      issue(1'b0, 11'h155, 8'h00);
      chk(!req_ready, "R8 slot full", req_ready, 0);
      for (int i = 0; i < 200 && !done; i++) @(negedge clk);
      chk(!req_ready, "R8 still held", req_ready, 0);
      for (int i = 0; i < 50 && mem_ce_n; i++) begin gap++; @(negedge clk); end
      chk(gap == EXP_REC + 1, "R7 recovery gap", gap, EXP_REC + 1);
      chk(gap >= EXP_REC, "R7 minimum gap", gap, EXP_REC);
      for (int i = 0; i < 200 && !done; i++) @(negedge clk);
      chk(rdata == 8'h3C, "R8 queued read data", rdata, 8'h3C);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 3 + 2);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_write(11'h000, 8'hA5);
      t_write(11'h7FF, 8'h5A);
      t_write(11'h123, 8'hFF);
      t_write(11'h124, 8'h00);
      t_read(11'h000, 8'hA5);
      t_read(11'h7FF, 8'h5A);
      t_read(11'h123, 8'hFF);
      t_read(11'h124, 8'h00);
      t_queued();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule